// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block owns the program counter of a single-cycle processor. Each cycle it places the counter on the instruction-memory address port, passes the returned instruction word straight to the decoder, and on the rising clock edge moves the counter on. The counter either steps to the next word or jumps to a target relative to the next word.

The jump is taken only when the decoder asserts the branch request and the ALU reports a zero result in the same cycle. The target is the next-word address plus the signed 16-bit offset held in the low half of the current instruction. The offset counts words, so it is scaled by four before the add.

A synchronous, active-high reset loads a start address set by a parameter. The counter is always word aligned. Address arithmetic wraps modulo two to the power of the address width.

Top module: `ifetch_npc`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes `RESET_ADDR` with its two low bits cleared (0x00000000 by default). This holds whatever `br_req` and `alu_zero` are.
- R2: `imem_addr` always equals `pc`, and `instr` always equals `imem_rdata` in the same cycle.
- R3: When `br_req` is 0 at a rising edge, `pc` advances by 4, whatever value `alu_zero` has.
- R4: When `br_req` is 1 and `alu_zero` is 0 at a rising edge, `pc` advances by 4.
- R5: When `br_req` and `alu_zero` are both 1 at a rising edge, `pc` becomes `pc + 4 + (offset << 2)`. The offset is `imem_rdata[15:0]` read as a two's-complement number.
- R6: A negative offset (bit 15 set) moves `pc` backward; for example, offset 0xFFFC from `pc` 28 gives 16.
- R7: `pc[1:0]` is 0 in every cycle after reset.
- R8: Address arithmetic wraps. From `pc` 0, a taken branch with offset 0xFFFE gives 0xFFFFFFFC, and the sequential step after that gives 0.
- R9: Bits 31:16 of the instruction word have no effect on the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| br_req | input | 1 | Decoder requests a conditional branch |
| alu_zero | input | 1 | ALU result-is-zero flag |
| imem_addr | output | 32 | Byte address to instruction memory |
| imem_rdata | input | 32 | Instruction word returned by memory |
| instr | output | 32 | Fetched instruction to the decoder |
| pc | output | 32 | Current program counter |

## Verification
The hardest case to reach from the ports is the wrap at the top of the address space. A counter that starts at zero would need about a billion sequential steps to get there. The stimulus instead resets to zero and takes a branch with offset 0xFFFE, which lands on 0xFFFFFFFC in one cycle. The next sequential step must then return to 0. Backward branches and the check that the upper instruction bits are ignored come from placing chosen words at the addresses the counter visits.

// File: rtl/ifetch_npc.sv
module ifetch_npc #(
  parameter int          ADDR_W     = 32,
  parameter int          IMM_W      = 16,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_req,
  input  logic              alu_zero,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic [31:0]       instr,
  output logic [ADDR_W-1:0] pc
);
  localparam int          ALIGN    = 2;
  localparam int          EXT_W    = ADDR_W - IMM_W - ALIGN;
  localparam [ADDR_W-1:0] STEP     = ADDR_W'(1 << ALIGN);
  localparam [ADDR_W-1:0] PC_START = {RESET_ADDR[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};

  logic [IMM_W-1:0]  offs;
  logic [ADDR_W-1:0] seq_pc, tgt_pc, nxt_pc;
  logic              take;

  assign imem_addr = pc;
  assign instr     = imem_rdata;
  assign offs      = imem_rdata[IMM_W-1:0];
  assign seq_pc    = pc + STEP;
  assign tgt_pc    = seq_pc + {{EXT_W{offs[IMM_W-1]}}, offs, {ALIGN{1'b0}}};
  assign take      = br_req & alu_zero;
  assign nxt_pc    = take ? tgt_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= PC_START;
    else     pc <= nxt_pc;
  end

  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> pc == PC_START);

  a_r3_seq_when_no_req: assert property (@(posedge clk) disable iff (rst)
    !br_req |=> pc == $past(pc) + STEP);

  a_r4_seq_when_nonzero: assert property (@(posedge clk) disable iff (rst)
    (br_req && !alu_zero) |=> pc == $past(pc) + STEP);

  a_r5_taken_moves: assert property (@(posedge clk) disable iff (rst)
    (br_req && alu_zero && imem_rdata[IMM_W-1:0] != '1) |=> pc != $past(pc));

  a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
    pc[ALIGN-1:0] == '0);

  always_comb begin
    a_r2_addr_follows_pc: assert (imem_addr === pc || $isunknown(pc));
  end
endmodule

// File: tb/ifetch_npc_test.sv
module ifetch_npc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_req = 1'b0;
  logic        alu_zero = 1'b0;
  logic [31:0] imem_addr, imem_rdata, instr, pc;
  logic [31:0] mem [64];
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  assign imem_rdata = mem[imem_addr[7:2]];

  ifetch_npc uut (
    .clk(clk), .rst(rst), .br_req(br_req), .alu_zero(alu_zero),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata), .instr(instr), .pc(pc)
  );

  localparam int NV = 8;
  // {br_req, alu_zero, instruction word, expected next pc}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b1, 32'h0000_0010, 32'd4},   // R3 zero ignored
    {1'b1, 1'b0, 32'h1234_0005, 32'd8},   // R4 not taken
    {1'b1, 1'b1, 32'h0000_0003, 32'd24},  // R5 forward
    {1'b0, 1'b0, 32'h0000_0000, 32'd28},  // R3
    {1'b1, 1'b1, 32'h0000_FFFC, 32'd16},  // R6 backward
    {1'b1, 1'b1, 32'hFFFF_0002, 32'd28},  // R9 upper bits ignored
    {1'b0, 1'b1, 32'h8000_FFFF, 32'd32},  // R3 negative offset, not taken
    {1'b1, 1'b1, 32'h0000_0000, 32'd36}   // R5 zero offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic step(input logic b, input logic z, input logic [31:0] w, input logic [31:0] exp);
    mem[pc[7:2]] = w;
    br_req = b;
    alu_zero = z;
    #1;
    check("R2 addr", imem_addr, pc);
    check("R2 instr", instr, w);
    @(posedge clk);
    @(negedge clk);
    check("R3/R4/R5/R6/R9 next pc", pc, exp);
    check("R7 align", {30'd0, pc[1:0]}, 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rst = 1'b1;
    br_req = 1'b1;
    alu_zero = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset", pc, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      step(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);

    // R1: reset mid-run with a taken branch pending
    mem[pc[7:2]] = 32'h0000_0040;
    br_req = 1'b1;
    alu_zero = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset mid-run", pc, 32'h0);
    rst = 1'b0;

    // R8: wrap through the top of the address space
    step(1'b1, 1'b1, 32'h0000_FFFE, 32'hFFFF_FFFC);
    step(1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000);
    // R8: backward branch from 0 wraps, then taken forward branch wraps back
    step(1'b1, 1'b1, 32'h0000_FFFE, 32'hFFFF_FFFC);
    step(1'b1, 1'b1, 32'h0000_0001, 32'h0000_0004);

    finish_up();
  end
endmodule